// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small single-port RAM of one-bit cells that can be told, at run time, to act as if one of its cells were defective. It exists to give a memory self-test engine a target whose defect is known in advance, so that a march sequence or a checkerboard pass can be shown to catch (or miss) a given defect class. With no defect loaded it behaves exactly like an ideal RAM.

A defect is described by a kind code, a victim address, an aggressor address, an aggressor edge selector, a forced value and an aggressor state. These fields are captured only on a cycle where the load strobe is high, and only one defect is active at a time. Supported kinds are stuck cells, failed rising or falling writes, three forms of coupling between two cells, and a cell whose content is upset by being read.

One operation is performed per clock: a write when the write enable is high, otherwise a read when the read enable is high. Read data appears one cycle after the read and then holds until the next read.

Top module: `fault_ram`

## Requirements
- R1: After reset every cell holds 0, the read data output is 0 and no defect is active (kind code 0).
- R2: With kind 0 the block is an ideal RAM: a write stores the write data, a read (read enable high, write enable low) returns the cell value on the read data output one cycle later, and the output holds its value in any cycle without a read.
- R3: The defect fields are captured only on a clock edge where the load strobe is high; changing them while the strobe is low has no effect on behaviour.
- R4: Kind 1 (stuck cell): every read of the victim returns the forced-value field, whatever was written.
- R5: Kind 2 (rising write failure): a write of 1 to the victim while it holds 0 leaves it at 0. Kind 3 (falling write failure): a write of 0 to the victim while it holds 1 leaves it at 1. Other writes to the victim act normally.
- R6: Kind 4 (inverting coupling): a write that changes the aggressor's stored value inverts the victim's stored value, provided the change matches the edge field: 0 = aggressor goes 0 to 1, 1 = aggressor goes 1 to 0, 2 or 3 = either direction.
- R7: Kind 5 (forcing coupling): a write that changes the aggressor in the direction selected by the edge field (same encoding as R6) sets the victim's stored value to the forced-value field.
- R8: Kind 6 (state coupling): a read of the victim returns the forced-value field whenever the aggressor cell currently holds the aggressor-state field, and the victim's stored value otherwise.
- R9: Kind 7 (read upset): a read of the victim returns the value held before the read and leaves the victim holding the inverted value.
- R10: The coupling kinds (4, 5, 6) have no effect when the victim and aggressor addresses are equal, and no defect ever alters a cell other than the victim and the cell being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | input | ADDR_W | Cell address for the current operation |
| mem_we | input | 1 | Write enable (takes priority over read) |
| mem_re | input | 1 | Read enable |
| mem_wdata | input | 1 | Write data |
| mem_rdata | output | 1 | Read data, one cycle after the read, held otherwise |
| flt_load | input | 1 | Strobe that captures the defect fields |
| flt_kind | input | 3 | Defect kind code (0 none .. 7 read upset) |
| flt_victim | input | ADDR_W | Victim cell address |
| flt_aggr | input | ADDR_W | Aggressor cell address |
| flt_edge | input | 2 | Aggressor edge selector for kinds 4 and 5 |
| flt_value | input | 1 | Forced value for kinds 1, 5 and 6 |
| flt_agg_state | input | 1 | Aggressor state that activates kind 6 |

## Verification
The hardest situation to reach from the ports is a coupling defect acting on a victim whose value then has to be observed: the aggressor must first be written to the opposite value, then flipped in the selected direction, and only a later read of the victim shows the effect. Random stimulus therefore restricts addresses mostly to the loaded victim and aggressor plus a few others, and sweeps edge selectors and forced values across many reloaded configurations, while a bench model predicts every read. Directed cases cover equal victim and aggressor addresses and the unloaded-field case.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

   typedef enum logic [2:0] {
      FK_NONE      = 3'd0,
      FK_STUCK     = 3'd1,
      FK_TF_RISE   = 3'd2,
      FK_TF_FALL   = 3'd3,
      FK_CPL_INV   = 3'd4,
      FK_CPL_FORCE = 3'd5,
      FK_CPL_STATE = 3'd6,
      FK_RD_UPSET  = 3'd7
   } fault_kind_e;

   localparam logic [1:0] EDGE_RISE = 2'd0;
   localparam logic [1:0] EDGE_FALL = 2'd1;

   typedef struct packed {
      fault_kind_e kind;
      logic [1:0]  edge_sel;
      logic        value;
      logic        agg_state;
   } fault_mode_t;

endpackage

// File: rtl/fault_ram_cfg.sv
module fault_ram_cfg
   import fault_ram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        kind_in,
   input  logic [ADDR_W-1:0] victim_in,
   input  logic [ADDR_W-1:0] aggr_in,
   input  logic [1:0]        edge_in,
   input  logic              value_in,
   input  logic              astate_in,
   output fault_mode_t       mode,
   output logic [ADDR_W-1:0] victim,
   output logic [ADDR_W-1:0] aggr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode.kind      <= FK_NONE;
         mode.edge_sel  <= 2'd0;
         mode.value     <= 1'b0;
         mode.agg_state <= 1'b0;
         victim         <= '0;
         aggr           <= '0;
      end else if (load) begin
         mode.kind      <= fault_kind_e'(kind_in);
         mode.edge_sel  <= edge_in;
         mode.value     <= value_in;
         mode.agg_state <= astate_in;
         victim         <= victim_in;
         aggr           <= aggr_in;
      end
   end

   p_cfg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mode.kind == $past(kind_in)) && (victim == $past(victim_in))
               && (aggr == $past(aggr_in)));

   p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mode) && $stable(victim) && $stable(aggr));

endmodule

// File: rtl/fault_ram_effect.sv
module fault_ram_effect
   import fault_ram_pkg::*;
#(
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  fault_mode_t       mode,
   input  logic [ADDR_W-1:0] victim,
   input  logic [ADDR_W-1:0] aggr,
   input  logic [DEPTH-1:0]  cells,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic              wdata,
   output logic              store_val,
   output logic              vic_upd,
   output logic              vic_val,
   output logic              rd_view
);

   logic old_bit, vic_bit, agg_bit;
   logic hit_vic, hit_agg, distinct;
   logic agg_change, edge_ok, rd_cycle;

   always_comb begin
      old_bit  = cells[addr];
      vic_bit  = cells[victim];
      agg_bit  = cells[aggr];
      hit_vic  = (addr == victim);
      hit_agg  = (addr == aggr);
      distinct = (victim != aggr);
      rd_cycle = re && !we;

      // write path: transition failures bend the stored value
      store_val = wdata;
      if (hit_vic && (mode.kind == FK_TF_RISE) && !old_bit && wdata)
         store_val = 1'b0;
      if (hit_vic && (mode.kind == FK_TF_FALL) && old_bit && !wdata)
         store_val = 1'b1;

      // aggressor activity for the coupling kinds
      agg_change = we && hit_agg && distinct && (old_bit != store_val);
      case (mode.edge_sel)
         EDGE_RISE: edge_ok = store_val;
         EDGE_FALL: edge_ok = !store_val;
         default:   edge_ok = 1'b1;
      endcase

      vic_upd = 1'b0;
      vic_val = vic_bit;
      case (mode.kind)
         FK_CPL_INV: begin
            if (agg_change && edge_ok) begin
               vic_upd = 1'b1;
               vic_val = !vic_bit;
            end
         end
         FK_CPL_FORCE: begin
            if (agg_change && edge_ok) begin
               vic_upd = 1'b1;
               vic_val = mode.value;
            end
         end
         FK_RD_UPSET: begin
            if (rd_cycle && hit_vic) begin
               vic_upd = 1'b1;
               vic_val = !vic_bit;
            end
         end
         default: ;
      endcase

      // read path: stuck and state-coupled cells override the stored bit
      rd_view = old_bit;
      if (hit_vic) begin
         if (mode.kind == FK_STUCK)
            rd_view = mode.value;
         else if ((mode.kind == FK_CPL_STATE) && distinct && (agg_bit == mode.agg_state))
            rd_view = mode.value;
      end
   end

endmodule

// File: rtl/fault_ram_store.sv
module fault_ram_store #(
   parameter int ADDR_W         = 6,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              store_val,
   input  logic              vic_upd,
   input  logic              vic_val,
   input  logic [ADDR_W-1:0] victim,
   output logic [DEPTH-1:0]  cells
);

   logic [DEPTH-1:0] cell_d;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign cell_d[i] = (vic_upd && (victim == ADDR_W'(i))) ? vic_val :
                         (we && (addr == ADDR_W'(i)))        ? store_val :
                                                               cells[i];
   end

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cells <= '0;
         else        cells <= cell_d;
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         cells <= cell_d;
      end
   end

   // only the written cell and the victim may change in a cycle
   p_locality_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cells ^ $past(cells))
                & ~(($past(we) ? (DEPTH'(1) << $past(addr)) : '0)
                    | ($past(vic_upd) ? (DEPTH'(1) << $past(victim)) : '0))) == '0);

endmodule

// File: rtl/fault_ram_rport.sv
module fault_ram_rport (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_cycle,
   input  logic rd_view,
   output logic rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata <= 1'b0;
      else if (rd_cycle) rdata <= rd_view;
   end

   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cycle |=> $stable(rdata));

endmodule

// File: rtl/fault_ram.sv
module fault_ram
   import fault_ram_pkg::*;
#(
   parameter int ADDR_W         = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_we,
   input  logic              mem_re,
   input  logic              mem_wdata,
   output logic              mem_rdata,
   input  logic              flt_load,
   input  logic [2:0]        flt_kind,
   input  logic [ADDR_W-1:0] flt_victim,
   input  logic [ADDR_W-1:0] flt_aggr,
   input  logic [1:0]        flt_edge,
   input  logic              flt_value,
   input  logic              flt_agg_state
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("fault_ram: ADDR_W must lie in 1..10");
   end

   fault_mode_t       mode;
   logic [ADDR_W-1:0] victim, aggr;
   logic [DEPTH-1:0]  cells;
   logic              store_val, vic_upd, vic_val, rd_view;

   fault_ram_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(flt_load),
      .kind_in(flt_kind), .victim_in(flt_victim), .aggr_in(flt_aggr),
      .edge_in(flt_edge), .value_in(flt_value), .astate_in(flt_agg_state),
      .mode(mode), .victim(victim), .aggr(aggr)
   );

   fault_ram_effect #(.ADDR_W(ADDR_W)) u_effect (
      .mode(mode), .victim(victim), .aggr(aggr), .cells(cells),
      .addr(mem_addr), .we(mem_we), .re(mem_re), .wdata(mem_wdata),
      .store_val(store_val), .vic_upd(vic_upd), .vic_val(vic_val),
      .rd_view(rd_view)
   );

   fault_ram_store #(.ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
      .store_val(store_val), .vic_upd(vic_upd), .vic_val(vic_val),
      .victim(victim), .cells(cells)
   );

   fault_ram_rport u_rport (
      .clk(clk), .rst_n(rst_n), .rd_cycle(mem_re && !mem_we),
      .rd_view(rd_view), .rdata(mem_rdata)
   );

   p_ideal_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.kind == FK_NONE) && mem_we |=> cells[$past(mem_addr)] == $past(mem_wdata));

   p_stuck_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.kind == FK_STUCK) && mem_re && !mem_we && (mem_addr == victim)
      |=> mem_rdata == $past(mode.value));

   p_rise_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.kind == FK_TF_RISE) && mem_we && (mem_addr == victim) && !cells[victim]
      |=> !cells[$past(victim)]);

   p_inv_couple_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.kind == FK_CPL_INV) && mode.edge_sel[1] && mem_we && (mem_addr == aggr)
      && (aggr != victim) && (cells[aggr] != mem_wdata)
      |=> cells[$past(victim)] != $past(cells[victim]));

   p_read_upset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.kind == FK_RD_UPSET) && mem_re && !mem_we && (mem_addr == victim)
      |=> (cells[$past(victim)] != $past(cells[victim]))
          && (mem_rdata == $past(cells[victim])));

endmodule

// File: tb/sim_fault_ram.sv
`timescale 1ns/1ps
module sim_fault_ram;

   localparam int AW = 6;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic          mem_we = 1'b0, mem_re = 1'b0, mem_wdata = 1'b0;
   logic          mem_rdata;
   logic          flt_load = 1'b0;
   logic [2:0]    flt_kind = 3'd0;
   logic [AW-1:0] flt_victim = '0, flt_aggr = '0;
   logic [1:0]    flt_edge = 2'd0;
   logic          flt_value = 1'b0, flt_agg_state = 1'b0;

   always #4 clk = ~clk;

   fault_ram #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .flt_load(flt_load), .flt_kind(flt_kind), .flt_victim(flt_victim),
      .flt_aggr(flt_aggr), .flt_edge(flt_edge), .flt_value(flt_value),
      .flt_agg_state(flt_agg_state)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  m [N];
   int  k_kind = 0, k_vic = 0, k_agg = 0, k_edge = 0;
   bit  k_val = 0, k_ast = 0;
   bit  exp_rd = 0;

   function automatic string req_of(int kind);
      case (kind)
         0: return "R2";
         1: return "R4";
         2, 3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic bit edge_match(int e, bit newv);
      if (e == 0) return newv;
      if (e == 1) return !newv;
      return 1'b1;
   endfunction

   task automatic check(string req, bit act, bit expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: rdata actual %0b expected %0b at %0t", req, act, expv, $time);
      end
   endtask

   // model step of one operation, written from the requirements
   task automatic model(bit w, bit r, int a, bit d);
      bit old, nv, v;
      if (w) begin
         old = m[a];
         nv  = d;
         if (k_kind == 2 && a == k_vic && !old && d) nv = 1'b0;
         if (k_kind == 3 && a == k_vic && old && !d) nv = 1'b1;
         m[a] = nv;
         if ((k_kind == 4 || k_kind == 5) && a == k_agg && k_agg != k_vic
             && old != nv && edge_match(k_edge, nv))
            m[k_vic] = (k_kind == 4) ? !m[k_vic] : k_val;
      end else if (r) begin
         v = m[a];
         if (a == k_vic) begin
            if (k_kind == 1) v = k_val;
            if (k_kind == 6 && k_agg != k_vic && m[k_agg] == k_ast) v = k_val;
            if (k_kind == 7) m[a] = !m[a];
         end
         exp_rd = v;
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic op(bit w, bit r, int a, bit d, string req);
      mem_we = w; mem_re = r; mem_addr = AW'(a); mem_wdata = d;
      model(w, r, a, d);
      @(negedge clk);
      mem_we = 1'b0; mem_re = 1'b0;
      check(req, mem_rdata, exp_rd);
   endtask

   task automatic load(int kind, int vic, int agg, int e, bit val, bit ast);
      flt_kind = 3'(kind); flt_victim = AW'(vic); flt_aggr = AW'(agg);
      flt_edge = 2'(e); flt_value = val; flt_agg_state = ast; flt_load = 1'b1;
      @(negedge clk);
      flt_load = 1'b0;
      k_kind = kind; k_vic = vic; k_agg = agg; k_edge = e; k_val = val; k_ast = ast;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", mem_rdata, 1'b0);
      op(0, 1, 5, 0, "R1");
      op(0, 1, 63, 0, "R1");

      // R2: ideal behaviour, latency and hold
      op(1, 0, 9, 1, "R2");
      op(0, 1, 9, 0, "R2");
      op(1, 0, 9, 0, "R2");     // write: output still holds 1
      op(0, 0, 9, 0, "R2");     // idle: output holds
      op(0, 1, 9, 0, "R2");

      // R3: fields changed without the strobe do nothing
      flt_kind = 3'd1; flt_victim = AW'(3); flt_value = 1'b1;
      @(negedge clk);
      op(1, 0, 3, 0, "R3");
      op(0, 1, 3, 0, "R3");

      // R4: stuck cells
      load(1, 3, 0, 0, 1, 0);
      op(1, 0, 3, 0, "R4");
      op(0, 1, 3, 0, "R4");
      load(1, 4, 0, 0, 0, 0);
      op(1, 0, 4, 1, "R4");
      op(0, 1, 4, 0, "R4");

      // R5: transition failures
      load(2, 7, 0, 0, 0, 0);
      op(1, 0, 7, 1, "R5");
      op(0, 1, 7, 0, "R5");
      load(3, 8, 0, 0, 0, 0);
      op(1, 0, 8, 1, "R5");
      op(1, 0, 8, 0, "R5");
      op(0, 1, 8, 0, "R5");

      // R6: inversion on rising aggressor only
      load(4, 11, 10, 0, 0, 0);
      op(1, 0, 10, 1, "R6");
      op(0, 1, 11, 0, "R6");
      op(1, 0, 10, 0, "R6");
      op(0, 1, 11, 0, "R6");

      // R10: equal victim and aggressor disables coupling
      load(5, 12, 12, 2, 1, 0);
      op(1, 0, 12, 1, "R10");
      op(1, 0, 12, 0, "R10");
      op(0, 1, 12, 0, "R10");

      // R9: read upset returns old value then stores inverse
      load(7, 20, 0, 0, 0, 0);
      op(1, 0, 20, 1, "R9");
      op(0, 1, 20, 0, "R9");
      op(0, 1, 20, 0, "R9");

      // random configurations, addresses biased to victim and aggressor
      for (int c = 0; c < 120; c++) begin
         int kind, vic, agg;
         kind = int'($urandom_range(0, 7));
         vic  = int'($urandom_range(0, N - 1));
         agg  = ($urandom_range(0, 9) == 0) ? vic : int'($urandom_range(0, N - 1));
         load(kind, vic, agg, int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         for (int s = 0; s < 80; s++) begin
            int sel, a, kop;
            sel = int'($urandom_range(0, 3));
            a = (sel == 0) ? vic : (sel == 1) ? agg :
                (sel == 2) ? ((vic + 1) % N) : int'($urandom_range(0, N - 1));
            kop = int'($urandom_range(0, 2));
            op(kop == 0, kop != 0, a, 1'($urandom_range(0, 1)),
               (agg == vic && kind >= 4 && kind <= 6) ? "R10" : req_of(kind));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule